// File: doc/BRIEF.md
# Segment-Bounded Serial RAM Loader

This block sits between a serial control port and a waveform RAM. When the port decodes a write command aimed at the RAM, the block collects the incoming serial bits into 32-bit words, most significant bit first. It writes each finished word to the next RAM location of the segment selected by the profile inputs. The transfer carries no length field. The number of words comes from the selected segment's first and last addresses, which the block reads from per-profile configuration inputs.

While a load is running, the block holds a suspend signal that stops the RAM read path. A finished load ends with a one-cycle completion pulse, and the suspend is released one cycle after that. Dropping chip select ends the transfer at once: a partly collected word is thrown away and no completion pulse is given.

Top module: `seg_ram_loader`

## Requirements
- R1: A load starts only when, while idle, `cmd_valid` is high with `sel` high and `cmd_byte` equal to 8'h0B (bit 7 clear means write, bits 4:0 hold address 0x0B). Any other byte, including the read form 8'h8B, starts nothing, and commands seen during a load are ignored.
- R2: The segment is the one that `profile_sel` picks in the cycle of the accepted command. Changing `profile_sel` later in the same load has no effect on addresses or word count.
- R3: Serial bits, taken one per cycle in which `bit_en` is high, fill each word most significant bit first: the first bit of a word becomes bit 31 of `ram_wdata`.
- R4: The first word is written at the segment's first address, and each later word at the address one above the previous one.
- R5: A load writes exactly last − first + 1 words. If last is below first, it writes one word. Bits that arrive after the final word are ignored.
- R6: `read_suspend` rises in the cycle after the accepted command and stays high through every `ram_we` of that load.
- R7: Lowering `sel` during a load discards the partial word, gives no `load_done`, and drops `read_suspend` in the next cycle.
- R8: `load_done` pulses for one cycle, one cycle after the last `ram_we`. `read_suspend` falls one cycle after `load_done`.
- R9: After reset, `ram_we`, `load_done` and `read_suspend` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Chip select, active high; low aborts a load |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_byte` holds a decoded instruction byte |
| cmd_byte | input | 8 | Instruction byte |
| bit_en | input | 1 | Serial bit strobe, one per serial clock rising edge |
| bit_in | input | 1 | Serial data bit |
| profile_sel | input | PROF_W | Profile (segment) select |
| seg_first_flat | input | NUM_PROF*ADDR_W | First address of each segment, profile 0 in the low bits |
| seg_last_flat | input | NUM_PROF*ADDR_W | Last address of each segment, profile 0 in the low bits |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | ADDR_W | RAM write address |
| ram_wdata | output | WORD_W | RAM write data |
| read_suspend | output | 1 | High while RAM reads must stay suspended |
| load_done | output | 1 | One-cycle pulse after the last word is written |

## Verification
The assertions run on every cycle. They check that each write falls inside the latched segment and lands while reads are suspended, that write addresses step by one, that the bit counter advances once per accepted bit, that a suspend only rises after a matching command, and that the completion and abort releases come at their fixed distances. The bench scenarios cover what only whole transfers can show: the exact word count, the bit order inside a word, that the profile is latched at the command, that excess bits and foreign commands have no effect, and that a partial word vanishes on abort.

// File: rtl/seg_ram_loader_pkg.sv
package seg_ram_loader_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RUN  = 2'd1,
    LD_LAST = 2'd2,
    LD_FLAG = 2'd3
  } ld_state_e;

  localparam logic [7:0] RAM_WRITE_CMD = 8'h0B;

  // Direction bit 7 clear (write) and address field 0x0B.
  function automatic logic is_ram_write(input logic [7:0] b);
    return b == RAM_WRITE_CMD;
  endfunction

endpackage

// File: rtl/slr_word_collector.sv
module slr_word_collector #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              bit_in,
  output logic              word_fire,
  output logic [WORD_W-1:0] word_out
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  assign word_fire = take && (bit_cnt == LAST_BIT);
  assign word_out  = {shreg[WORD_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (clr) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (take) begin
      shreg   <= word_out;
      bit_cnt <= word_fire ? '0 : bit_cnt + 1'b1;
    end
  end

  // R3: each accepted bit short of a full word moves the count by one
  assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && !word_fire) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

  // R3: a finished word restarts the count
  assert_word_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_fire && !clr) |=> (bit_cnt == '0));

endmodule

// File: rtl/slr_addr_seq.sv
module slr_addr_seq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_word
);
  localparam int CNT_W = ADDR_W + 1;

  // Words in a segment; a reversed pair yields a single word.
  function automatic logic [CNT_W-1:0] seg_words(input logic [ADDR_W-1:0] lo,
                                                  input logic [ADDR_W-1:0] hi);
    if (hi < lo) return CNT_W'(1);
    return CNT_W'(hi) - CNT_W'(lo) + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] remaining;

  assign last_word = (remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
    end else if (load) begin
      cur_addr  <= first;
      remaining <= seg_words(first, last);
    end else if (step) begin
      cur_addr  <= cur_addr + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end

  // R4: consecutive words go to consecutive addresses
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R5: the count never steps below its final word
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && last_word) |=> (remaining == '0));

endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader
  import seg_ram_loader_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PROF_W = 2,
  parameter int WORD_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sel,
  input  logic                            cmd_valid,
  input  logic [7:0]                      cmd_byte,
  input  logic                            bit_en,
  input  logic                            bit_in,
  input  logic [PROF_W-1:0]               profile_sel,
  input  logic [(1<<PROF_W)*ADDR_W-1:0]   seg_first_flat,
  input  logic [(1<<PROF_W)*ADDR_W-1:0]   seg_last_flat,
  output logic                            ram_we,
  output logic [ADDR_W-1:0]               ram_waddr,
  output logic [WORD_W-1:0]               ram_wdata,
  output logic                            read_suspend,
  output logic                            load_done
);
  localparam int NUM_PROF = 1 << PROF_W;

  ld_state_e         state, state_nx;
  logic              start_ev, abort_ev, take_ev, word_fire, last_word;
  logic [WORD_W-1:0] word_val;
  logic [ADDR_W-1:0] cur_addr, sel_first, sel_last, lat_first, lat_last;
  logic [ADDR_W-1:0] first_tab [NUM_PROF];
  logic [ADDR_W-1:0] last_tab  [NUM_PROF];

  for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
    assign first_tab[p] = seg_first_flat[p*ADDR_W +: ADDR_W];
    assign last_tab[p]  = seg_last_flat[p*ADDR_W +: ADDR_W];
  end

  assign sel_first = first_tab[profile_sel];
  assign sel_last  = last_tab[profile_sel];

  // Named events, used by the logic and by the assertions.
  assign start_ev = (state == LD_IDLE) && cmd_valid && sel && is_ram_write(cmd_byte);
  assign abort_ev = (state == LD_RUN) && !sel;
  assign take_ev  = (state == LD_RUN) && sel && bit_en;

  slr_word_collector #(.WORD_W(WORD_W)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_ev),
    .take      (take_ev),
    .bit_in    (bit_in),
    .word_fire (word_fire),
    .word_out  (word_val)
  );

  slr_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ev),
    .first     (sel_first),
    .last      (sel_last),
    .step      (word_fire),
    .cur_addr  (cur_addr),
    .last_word (last_word)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      LD_IDLE: if (start_ev) state_nx = LD_RUN;
      LD_RUN: begin
        if (abort_ev)                    state_nx = LD_IDLE;
        else if (word_fire && last_word) state_nx = LD_LAST;
      end
      LD_LAST: state_nx = LD_FLAG;
      LD_FLAG: state_nx = LD_IDLE;
      default: state_nx = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LD_IDLE;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
      lat_first <= '0;
      lat_last  <= '0;
    end else begin
      state  <= state_nx;
      ram_we <= word_fire;
      if (word_fire) begin
        ram_waddr <= cur_addr;
        ram_wdata <= word_val;
      end
      if (start_ev) begin
        lat_first <= sel_first;
        lat_last  <= sel_last;
      end
    end
  end

  assign read_suspend = (state != LD_IDLE);
  assign load_done    = (state == LD_FLAG);

  // R1: suspension only begins after an accepted write command
  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_suspend) |-> ($past(cmd_valid) && $past(sel) && $past(cmd_byte) == RAM_WRITE_CMD));

  // R5: every write stays inside the latched segment
  assert_in_segment_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_waddr >= lat_first && (ram_waddr <= lat_last || lat_last < lat_first)));

  // R6: writes happen only while reads are suspended
  assert_we_suspended_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> read_suspend);

  // R7: an abort releases suspension at once and writes nothing
  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (!read_suspend && !ram_we && !load_done));

  // R8: completion follows the final write by one cycle
  assert_done_after_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(ram_we));

  // R8: suspension ends one cycle after completion
  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !read_suspend);

endmodule

// File: tb/test_seg_ram_loader.sv
module test_seg_ram_loader;
  localparam int AW = 10;
  localparam int PW = 2;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, cmd_valid = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [PW-1:0] profile_sel = '0;
  logic [4*AW-1:0] seg_first_flat = '0, seg_last_flat = '0;
  logic ram_we, read_suspend, load_done;
  logic [AW-1:0] ram_waddr;
  logic [WW-1:0] ram_wdata;

  int checks = 0, errors = 0;

  seg_ram_loader #(.ADDR_W(AW), .PROF_W(PW), .WORD_W(WW)) i_seg_ram_loader (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .bit_en(bit_en), .bit_in(bit_in), .profile_sel(profile_sel),
    .seg_first_flat(seg_first_flat), .seg_last_flat(seg_last_flat),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .read_suspend(read_suspend), .load_done(load_done));

  always #10 clk = ~clk;

  // Log of observed activity, sampled at falling edges.
  int cyc = 0, nw = 0, nd = 0, last_we_cyc = -1, done_cyc = -1, fall_cyc = -1, bad_we = 0;
  logic [AW-1:0] wa [64];
  logic [WW-1:0] wd [64];
  logic prev_s = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (ram_we) begin
      if (nw < 64) begin wa[nw] = ram_waddr; wd[nw] = ram_wdata; end
      nw++;
      last_we_cyc = cyc;
      if (!read_suspend) bad_we++;
    end
    if (load_done) begin nd++; done_cyc = cyc; end
    if (prev_s && !read_suspend) fall_cyc = cyc;
    prev_s = read_suspend;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk); #1;
    nw = 0; nd = 0; last_we_cyc = -1; done_cyc = -1; fall_cyc = -1; bad_we = 0;
  endtask

  function automatic int words_for(input int lo, input int hi);
    return (hi >= lo) ? hi - lo + 1 : 1;
  endfunction

  function automatic logic [WW-1:0] pat(input int k);
    return 32'h8000_0001 ^ (32'h1357_9BDF * k);
  endfunction

  task automatic set_seg(input int p, input int lo, input int hi);
    seg_first_flat[p*AW +: AW] = AW'(lo);
    seg_last_flat[p*AW +: AW]  = AW'(hi);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); sel = 1'b1; cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_bits(input logic [WW-1:0] w, input int n, input bit gaps);
    for (int i = WW - 1; i >= WW - n; i--) begin
      bit_en = 1'b1; bit_in = w[i];
      @(negedge clk);
      if (gaps && (i % 3 == 0)) begin bit_en = 1'b0; @(negedge clk); end
    end
    bit_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!ram_we, "R9 ram_we", ram_we, 0);
    check(!load_done, "R9 load_done", load_done, 0);
    check(!read_suspend, "R9 read_suspend", read_suspend, 0);
  endtask

  task automatic t_basic();
    int n;
    set_seg(1, 8, 11);
    profile_sel = 2'd1;
    clear_log();
    send_cmd(8'h0B);
    check(read_suspend, "R6 suspend after command", read_suspend, 1);
    n = words_for(8, 11);
    for (int k = 0; k < n; k++) send_bits(pat(k), WW, k == 1);
    idle(5);
    check(nw == n, "R5 word count", nw, n);
    for (int k = 0; k < n; k++) begin
      check(wa[k] == AW'(8 + k), "R4 address", wa[k], 8 + k);
      check(wd[k] == pat(k), "R3 data", wd[k], pat(k));
    end
    check(nd == 1, "R8 one done pulse", nd, 1);
    check(done_cyc == last_we_cyc + 1, "R8 done timing", done_cyc, last_we_cyc + 1);
    check(fall_cyc == done_cyc + 1, "R8 release timing", fall_cyc, done_cyc + 1);
    check(bad_we == 0, "R6 writes while suspended", bad_we, 0);
  endtask

  task automatic t_foreign_cmds();
    clear_log();
    send_cmd(8'h8B);
    check(!read_suspend, "R1 read form ignored", read_suspend, 0);
    send_cmd(8'h0A);
    check(!read_suspend, "R1 other address ignored", read_suspend, 0);
    send_bits(pat(3), WW, 1'b0);
    idle(3);
    check(nw == 0, "R1 no writes", nw, 0);
  endtask

  task automatic t_profile_latch();
    set_seg(2, 20, 21);
    set_seg(0, 40, 45);
    profile_sel = 2'd2;
    clear_log();
    send_cmd(8'h0B);
    profile_sel = 2'd0;
    for (int k = 0; k < 2; k++) send_bits(pat(k + 7), WW, 1'b0);
    idle(5);
    check(nw == 2, "R2 count from latched profile", nw, 2);
    check(wa[0] == AW'(20), "R2 first address", wa[0], 20);
    check(wa[1] == AW'(21), "R2 second address", wa[1], 21);
  endtask

  task automatic t_excess_bits();
    set_seg(3, 5, 5);
    profile_sel = 2'd3;
    clear_log();
    send_cmd(8'h0B);
    send_cmd(8'h0B);
    send_bits(pat(4), WW, 1'b0);
    send_bits(pat(5), WW, 1'b0);
    idle(3);
    check(nw == 1, "R5 excess bits ignored", nw, 1);
    check(wa[0] == AW'(5), "R5 single word address", wa[0], 5);
    check(wd[0] == pat(4), "R1 command during load ignored", wd[0], pat(4));
    check(nd == 1, "R8 done for single word", nd, 1);
  endtask

  task automatic t_abort();
    set_seg(1, 8, 11);
    profile_sel = 2'd1;
    clear_log();
    send_cmd(8'h0B);
    send_bits(pat(9), WW, 1'b0);
    send_bits(pat(10), 10, 1'b0);
    sel = 1'b0;
    @(negedge clk);
    check(!read_suspend, "R7 release next cycle", read_suspend, 0);
    idle(4);
    check(nw == 1, "R7 partial word dropped", nw, 1);
    check(nd == 0, "R7 no done on abort", nd, 0);
  endtask

  task automatic t_reversed();
    set_seg(0, 30, 12);
    profile_sel = 2'd0;
    clear_log();
    send_cmd(8'h0B);
    send_bits(pat(11), WW, 1'b0);
    send_bits(pat(12), WW, 1'b0);
    idle(3);
    check(nw == words_for(30, 12), "R5 reversed segment", nw, 1);
    check(wa[0] == AW'(30), "R4 reversed start address", wa[0], 30);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_foreign_cmds();
    t_profile_latch();
    t_excess_bits();
    t_abort();
    t_reversed();
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule